// File: doc/BRIEF.md
# Real-Time Clock Calibration Prescaler

This block turns a 32,768 Hz crystal clock into a once-per-second tick and a once-per-minute tick. It trims the clock rate in digital logic and leaves the crystal alone. A 6-bit trim word sets the correction. Bit 5 is the direction: 1 makes the clock run fast and 0 makes it run slow. Bits 4:0 hold a step count N from 0 to 31.

The block keeps its own second-within-minute counter and minute-within-cycle counter. A correction cycle is 64 minutes long. The first second of each of the first 2N minutes in that cycle is either shortened or lengthened. A shortened second loses 256 oscillator cycles, so the clock gains time. A lengthened second gains 128 cycles, so the clock loses time. The trim word is latched once, at the start of each minute. A write to it therefore never cuts short or stretches a second that has already started.

A separate, uncorrected divider produces a 512 Hz test square wave used to measure the crystal. That wave appears on its output only when the halt input is low, the test-enable input is high, the alarm-pin and square-wave enables are both low, and the watchdog word is zero. A stop input freezes every counter.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While reset is asserted, `sec_tick_o`, `min_tick_o` and `ft_o` are low. Reset places all counters at second 0 of minute 0 of a new 64-minute cycle.
- R2: With a step count of 0, every second lasts exactly `CYC_PER_SEC` oscillator cycles. This is 32,768 by default.
- R3: With `cal_i[5]`=1 and step count N>0, second 0 of minutes 0 to 2N-1 lasts `CYC_PER_SEC-FAST_TRIM` cycles. By default that is 32,768-256.
- R4: With `cal_i[5]`=0 and step count N>0, second 0 of minutes 0 to 2N-1 lasts `CYC_PER_SEC+SLOW_TRIM` cycles. By default that is 32,768+128.
- R5: All other seconds last exactly `CYC_PER_SEC` cycles. This covers seconds 1 and later of every minute, and every second of minutes 2N to 63. Minutes 62 and 63 are never trimmed.
- R6: `min_tick_o` pulses only in the same cycle as the `sec_tick_o` that ends the last second of a minute. After 64 minutes the minute count wraps to 0.
- R7: One full 64-minute cycle lasts 64·`SEC_PER_MIN`·`CYC_PER_SEC` cycles. The fast direction subtracts 2N·`FAST_TRIM` from that count. The slow direction adds 2N·`SLOW_TRIM`.
- R8: The trim word is sampled in the first oscillator cycle of each minute. A change made later in the minute takes effect in the next minute. This holds even when the change comes during second 0.
- R9: While `stop_i` is high, all counters hold and no ticks are produced. When `stop_i` returns low, counting resumes with the interrupted second keeping its expected length.
- R10: When the test gate is open, `ft_o` toggles every `FT_HALF` cycles. That is every 32 cycles by default, giving 512 Hz.
- R11: `ft_o` stays low when any one gate condition fails. The gate conditions are: `stop_i` low, `ftest_i` high, `alarm_en_i` low, `sqw_en_i` low, and `wdog_i` zero.
- R12: The toggle spacing of `ft_o` does not depend on the trim word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock (32,768 Hz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Freezes all counters when high |
| cal_i | input | 6 | Trim word: bit 5 = fast (1) / slow (0), bits 4:0 = step count |
| ftest_i | input | 1 | Frequency-test enable |
| alarm_en_i | input | 1 | Alarm-pin enable; blocks the test wave when high |
| sqw_en_i | input | 1 | Square-wave enable; blocks the test wave when high |
| wdog_i | input | WDOG_W | Watchdog word; blocks the test wave when nonzero |
| sec_tick_o | output | 1 | One-cycle pulse that ends each second |
| min_tick_o | output | 1 | One-cycle pulse that ends each minute |
| ft_o | output | 1 | Gated 512 Hz frequency-test wave |

## Verification
Two events can fall in the same cycle: the trim word being latched at the start of a minute, and a write to that trim word.

The bench writes a new value just after one minute has started and another value in the middle of second 0 of a later minute. It then judges the recorded lengths of those seconds against the value that was present in each minute's first cycle.

A second collision comes from raising `stop_i` in exactly the cycle that would end a shortened second. The bench requires that the tick is held back and that the second still ends up with its trimmed length.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Trim word layout: bit 5 chooses direction, bits 4:0 count steps
  typedef struct packed {
    logic       fast;
    logic [4:0] steps;
  } cal_word_t;

  // A step count N trims the first 2N minutes of the cycle
  function automatic logic minute_in_window(int unsigned minute, logic [4:0] steps);
    return minute < (2 * 32'(steps));
  endfunction

  // Oscillator cycles in one second after any trim
  function automatic int unsigned second_length(int unsigned nominal,
                                                int unsigned shorten,
                                                int unsigned lengthen,
                                                logic        trim_fast,
                                                logic        trim_slow);
    if (trim_fast) return nominal - shorten;
    if (trim_slow) return nominal + lengthen;
    return nominal;
  endfunction

endpackage

// File: rtl/rtc_cal_sec_div.sv
module rtc_cal_sec_div
  import rtc_cal_pkg::*;
#(
  parameter int unsigned NOMINAL  = 32768,
  parameter int unsigned SHORTEN  = 256,
  parameter int unsigned LENGTHEN = 128
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic run,
  input  logic trim_fast,
  input  logic trim_slow,
  output logic sec_first,
  output logic sec_tick
);
  localparam int unsigned LONGEST = NOMINAL + LENGTHEN;
  localparam int unsigned CNT_W   = $clog2(LONGEST);

  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] last_idx;

  always_comb last_idx = CNT_W'(second_length(NOMINAL, SHORTEN, LENGTHEN,
                                              trim_fast, trim_slow) - 32'd1);

  assign sec_first = (cyc_q == '0);
  assign sec_tick  = run && (cyc_q == last_idx);

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)        cyc_q <= '0;
    else if (sec_tick) cyc_q <= '0;
    else if (run)      cyc_q <= cyc_q + 1'b1;
  end

  // R9
  sec_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !run |=> $stable(cyc_q));

  // R2
  sec_restart_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sec_tick |=> sec_first);

  // R3 R4 R5
  sec_bound_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sec_tick |-> ((32'(cyc_q) + 32'd1 >= NOMINAL - SHORTEN) &&
                  (32'(cyc_q) + 32'd1 <= LONGEST)));

endmodule

// File: rtl/rtc_cal_cycle_ctr.sv
module rtc_cal_cycle_ctr
  import rtc_cal_pkg::*;
#(
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned MIN_PER_CYCLE = 64
) (
  input  logic      clk_osc,
  input  logic      rst_n,
  input  logic      run,
  input  logic      sec_first,
  input  logic      sec_tick,
  input  cal_word_t cal_in,
  output logic      trim_fast,
  output logic      trim_slow,
  output logic      min_tick
);
  localparam int unsigned SEC_W = $clog2(SEC_PER_MIN);
  localparam int unsigned MIN_W = $clog2(MIN_PER_CYCLE);

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  cal_word_t        cal_q;

  logic cal_grab;
  logic last_sec;
  logic cycle_end;
  logic in_window;

  assign cal_grab  = run && sec_first && (sec_q == '0);
  assign last_sec  = (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign min_tick  = sec_tick && last_sec;
  assign cycle_end = min_tick && (min_q == MIN_W'(MIN_PER_CYCLE - 1));
  assign in_window = (sec_q == '0) && minute_in_window(32'(min_q), cal_q.steps);
  assign trim_fast = in_window &&  cal_q.fast;
  assign trim_slow = in_window && !cal_q.fast;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      cal_q <= '0;
    end else begin
      if (cal_grab) cal_q <= cal_in;
      if (sec_tick) sec_q <= last_sec ? '0 : sec_q + 1'b1;
      if (min_tick) min_q <= cycle_end ? '0 : min_q + 1'b1;
    end
  end

  // R6
  min_restart_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    min_tick |=> (sec_q == '0));

  // R6
  cycle_wrap_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    cycle_end |=> (min_q == '0));

  // R8
  cal_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !cal_grab |=> $stable(cal_q));

endmodule

// File: rtl/rtc_cal_ft_gen.sv
module rtc_cal_ft_gen #(
  parameter int unsigned HALF_PERIOD = 32
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic run,
  input  logic gate_open,
  output logic ft_out
);
  localparam int unsigned CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             ft_q;
  logic             flip;

  assign flip   = run && (cnt_q == CNT_W'(HALF_PERIOD - 1));
  assign ft_out = gate_open && ft_q;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ft_q  <= 1'b0;
    end else if (flip) begin
      cnt_q <= '0;
      ft_q  <= ~ft_q;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  ft_phase_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    flip |=> (cnt_q == '0) && (ft_q != $past(ft_q)));

endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int unsigned CYC_PER_SEC   = 32768,
  parameter int unsigned FAST_TRIM     = 256,
  parameter int unsigned SLOW_TRIM     = 128,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned MIN_PER_CYCLE = 64,
  parameter int unsigned FT_HALF       = 32,
  parameter int unsigned WDOG_W        = 8
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic [5:0]        cal_i,
  input  logic              ftest_i,
  input  logic              alarm_en_i,
  input  logic              sqw_en_i,
  input  logic [WDOG_W-1:0] wdog_i,
  output logic              sec_tick_o,
  output logic              min_tick_o,
  output logic              ft_o
);
  logic      run;
  logic      gate_open;
  logic      sec_first;
  logic      trim_fast;
  logic      trim_slow;
  cal_word_t cal_w;

  assign run       = !stop_i;
  assign cal_w     = cal_word_t'(cal_i);
  assign gate_open = run && ftest_i && !alarm_en_i && !sqw_en_i && (wdog_i == '0);

  rtc_cal_sec_div #(
    .NOMINAL (CYC_PER_SEC),
    .SHORTEN (FAST_TRIM),
    .LENGTHEN(SLOW_TRIM)
  ) u_sec_div (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .run      (run),
    .trim_fast(trim_fast),
    .trim_slow(trim_slow),
    .sec_first(sec_first),
    .sec_tick (sec_tick_o)
  );

  rtc_cal_cycle_ctr #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_CYCLE(MIN_PER_CYCLE)
  ) u_cycle_ctr (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .run      (run),
    .sec_first(sec_first),
    .sec_tick (sec_tick_o),
    .cal_in   (cal_w),
    .trim_fast(trim_fast),
    .trim_slow(trim_slow),
    .min_tick (min_tick_o)
  );

  rtc_cal_ft_gen #(
    .HALF_PERIOD(FT_HALF)
  ) u_ft_gen (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .run      (run),
    .gate_open(gate_open),
    .ft_out   (ft_o)
  );

  // R9
  stop_quiet_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    stop_i |-> (!sec_tick_o && !min_tick_o && !ft_o));

  // R6
  min_with_sec_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    min_tick_o |-> sec_tick_o);

endmodule

// File: tb/rtc_cal_prescaler_test.sv
`timescale 1ns/1ps
module rtc_cal_prescaler_test;
  localparam int CYC = 64;
  localparam int SH  = 16;
  localparam int LN  = 8;
  localparam int SPM = 2;
  localparam int MPC = 64;
  localparam int FH  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop = 1'b0;
  logic [5:0] cal = '0;
  logic       ftest = 1'b0;
  logic       aen = 1'b0;
  logic       sqw = 1'b0;
  logic [7:0] wdog = '0;
  logic       sec_tick, min_tick, ft;

  always #2.5 clk = ~clk;

  rtc_cal_prescaler #(
    .CYC_PER_SEC(CYC), .FAST_TRIM(SH), .SLOW_TRIM(LN),
    .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC), .FT_HALF(FH), .WDOG_W(8)
  ) uut (
    .clk_osc(clk), .rst_n(rst_n), .stop_i(stop), .cal_i(cal),
    .ftest_i(ftest), .alarm_en_i(aen), .sqw_en_i(sqw), .wdog_i(wdog),
    .sec_tick_o(sec_tick), .min_tick_o(min_tick), .ft_o(ft)
  );

  int n_chk = 0;
  int n_bad = 0;

  bit         mon_on = 0;
  int         cyc_in_sec, sec_idx, min_idx, cyc_total;
  logic [5:0] exp_cal;
  bit         cycle_done;
  int         len_log [MPC][SPM];
  int         ticks_in_stop;
  int         ft_mode = 0, prev_mode = 0, ft_cnt = 0, ft_low_bad = 0;
  bit         ft_valid = 0;
  logic       ft_prev = 1'b0;
  int         e;
  string      tag;

  function automatic int exp_len(int m, int s, logic [5:0] c);
    int steps = int'(c[4:0]);
    if (s == 0 && m < 2 * steps) return c[5] ? CYC - SH : CYC + LN;
    return CYC;
  endfunction

  task automatic chk(bit ok, string t, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (stop) begin
        if (sec_tick || min_tick) ticks_in_stop++;
      end else begin
        cyc_in_sec++;
        cyc_total++;
        if (sec_idx == 0 && cyc_in_sec == 1) exp_cal = cal;
        if (min_tick && !sec_tick) chk(1'b0, "R6", 1, 0);
        if (sec_tick) begin
          e = exp_len(min_idx, sec_idx, exp_cal);
          if (e == CYC) tag = (exp_cal[4:0] == 0) ? "R2" : "R5";
          else          tag = exp_cal[5] ? "R3" : "R4";
          chk(cyc_in_sec == e, tag, cyc_in_sec, e);
          len_log[min_idx][sec_idx] = cyc_in_sec;
          chk(int'(min_tick) == int'(sec_idx == SPM - 1), "R6",
              int'(min_tick), int'(sec_idx == SPM - 1));
          cyc_in_sec = 0;
          if (sec_idx == SPM - 1) begin
            sec_idx = 0;
            if (min_idx == MPC - 1) begin
              min_idx = 0;
              cycle_done = 1;
            end else min_idx++;
          end else sec_idx++;
        end
      end
    end
    if (ft_mode != prev_mode) begin
      ft_valid  = 0;
      ft_cnt    = 0;
      prev_mode = ft_mode;
    end
    if (ft_mode == 1) begin
      ft_cnt++;
      if (ft !== ft_prev) begin
        if (ft_valid) chk(ft_cnt == FH, (cal[4:0] != 0) ? "R12" : "R10", ft_cnt, FH);
        ft_valid = 1;
        ft_cnt   = 0;
      end
    end else if (ft_mode == 2) begin
      if (ft !== 1'b0) ft_low_bad++;
    end
    ft_prev = ft;
  end

  task automatic start_run(logic [5:0] c);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cal   = c;
    stop  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!sec_tick && !min_tick && !ft, "R1",
        int'({sec_tick, min_tick, ft}), 0);
    cyc_in_sec = 0; sec_idx = 0; min_idx = 0; cyc_total = 0;
    cycle_done = 0; exp_cal = c; mon_on = 1;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic run_full(logic [5:0] c);
    int n;
    int expv;
    start_run(c);
    wait (cycle_done);
    n = 2 * int'(c[4:0]);
    if (n > MPC) n = MPC;
    expv = MPC * SPM * CYC + (c[5] ? -n * SH : n * LN);
    // R7: whole-cycle length
    chk(cyc_total == expv, "R7", cyc_total, expv);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int mags [6] = '{0, 1, 6, 15, 30, 31};
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 6; k++)
        run_full({s[0], 5'(mags[k])});

    // R8: writes near and inside the minute-start sampling
    start_run(6'b1_11111);
    wait (min_idx == 5 && sec_idx == 1);
    @(posedge clk); #1 cal = 6'b0_11111;
    wait (min_idx == 7 && sec_idx == 0 && cyc_in_sec == 10);
    @(posedge clk); #1 cal = 6'b0_00000;
    wait (min_idx == 8);
    chk(len_log[5][0] == CYC - SH, "R8", len_log[5][0], CYC - SH);
    chk(len_log[5][1] == CYC,      "R8", len_log[5][1], CYC);
    chk(len_log[6][0] == CYC + LN, "R8", len_log[6][0], CYC + LN);
    chk(len_log[7][0] == CYC + LN, "R8", len_log[7][0], CYC + LN);

    // R9: stop mid-second and on the would-be tick cycle
    start_run(6'b1_00001);
    wait (min_idx == 0 && sec_idx == 1 && cyc_in_sec == 20);
    @(posedge clk); #1 stop = 1'b1;
    ticks_in_stop = 0;
    repeat (50) @(posedge clk);
    #1 stop = 1'b0;
    chk(ticks_in_stop == 0, "R9", ticks_in_stop, 0);
    wait (min_idx == 1 && sec_idx == 0 && cyc_in_sec == CYC - SH - 1);
    @(posedge clk); #1 stop = 1'b1;
    repeat (10) @(posedge clk);
    #1 stop = 1'b0;
    chk(ticks_in_stop == 0, "R9", ticks_in_stop, 0);
    wait (sec_idx == 1);
    chk(len_log[0][1] == CYC,      "R9", len_log[0][1], CYC);
    chk(len_log[1][0] == CYC - SH, "R9", len_log[1][0], CYC - SH);

    // R10 / R12: test wave spacing under several trim words
    start_run(6'b0_00000);
    @(posedge clk); #1 ftest = 1'b1; ft_mode = 1;
    repeat (100) @(posedge clk);
    #1 cal = 6'b1_11111;
    repeat (100) @(posedge clk);
    #1 cal = 6'b0_10101;
    repeat (100) @(posedge clk);
    #1 ft_mode = 0;

    // R11: each gate condition alone closes the wave
    for (int g = 0; g < 5; g++) begin
      @(posedge clk); #1;
      case (g)
        0: ftest = 1'b0;
        1: aen   = 1'b1;
        2: sqw   = 1'b1;
        3: wdog  = 8'h01;
        default: stop = 1'b1;
      endcase
      ft_low_bad = 0;
      ft_mode = 2;
      repeat (30) @(posedge clk);
      #1 ft_mode = 0;
      chk(ft_low_bad == 0, "R11", ft_low_bad, 0);
      ftest = 1'b1; aen = 1'b0; sqw = 1'b0; wdog = '0; stop = 1'b0;
    end

    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

endmodule